// File: doc/BRIEF.md
# JTAG Secure-Mode Instruction Filter

This block sits between the instruction register of a JTAG test access port and the instruction decoder. On every Update-IR strobe it decides which instruction the decoder sees. While the device is in secure mode, only the instructions that every boundary-scan device must support reach the decoder. Any other opcode is replaced with the bypass code, so the scan path falls to the one-bit bypass register.

Secure mode starts from a configuration bit that is loaded whenever configuration is reloaded. Two dedicated opcodes move the block in and out of secure mode: a lock code enters it and an unlock code leaves it. Both take effect only when they arrive through the external JTAG pins. When either code comes from the internal access path used by user logic, it changes nothing. The lock and unlock codes always reach the decoder, so a locked device can still be unlocked. A Test-Logic-Reset loads IDCODE into the effective instruction and leaves the secure state as it was.

Top module: `jsf_sec_filter`

## Requirements
- R1: While `rstN` is low, and after it is released, `secureActive` equals `cfgSecureEn` and `effInstr` holds the IDCODE code (10'h006).
- R2: While secure, an Update-IR strobe carrying a mandatory opcode loads that opcode unchanged into `effInstr` after the clock edge. The mandatory opcodes are BYPASS 10'h3FF, SAMPLE/PRELOAD 10'h005, EXTEST 10'h00F and IDCODE 10'h006.
- R3: While secure, an Update-IR strobe carrying any opcode that is not mandatory and is not LOCK or UNLOCK loads BYPASS (10'h3FF) into `effInstr`.
- R4: While not secure, an Update-IR strobe loads any opcode unchanged into `effInstr`.
- R5: An Update-IR strobe with UNLOCK (10'h1F1) and `fromExtPort` high clears `secureActive` at the same clock edge that updates `effInstr`.
- R6: An Update-IR strobe with LOCK (10'h1F0) and `fromExtPort` high sets `secureActive` at the same clock edge.
- R7: An Update-IR strobe with `fromExtPort` low leaves `secureActive` unchanged, including when it carries LOCK or UNLOCK.
- R8: LOCK and UNLOCK are loaded unchanged into `effInstr` in both states and from both access paths.
- R9: A `tlReset` strobe loads IDCODE into `effInstr`, takes priority over a simultaneous Update-IR, and leaves `secureActive` unchanged.
- R10: When neither strobe is high, `effInstr` and `secureActive` hold their values whatever `irCode`, `fromExtPort` and `cfgSecureEn` do.
- R11: A configuration reload (low pulse on `rstN`) restores `secureActive` to the current `cfgSecureEn`, whatever state the lock codes had set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | TCK-domain clock |
| rstN | input | 1 | Configuration reload, asynchronous, active low |
| cfgSecureEn | input | 1 | Secure-mode enable bit from configuration data |
| updateIr | input | 1 | Update-IR state strobe from the TAP controller |
| tlReset | input | 1 | Test-Logic-Reset state strobe |
| irCode | input | 10 | Instruction code shifted into the instruction register |
| fromExtPort | input | 1 | High when the instruction came through the external JTAG pins |
| effInstr | output | 10 | Instruction passed on to the decoder |
| secureActive | output | 1 | High while secure mode is in force |

## Verification
Each strobe sampled at a rising edge produces its result on `effInstr` and `secureActive` right after that edge, one register deep, and the lock state seen by that same strobe is the one from before the edge. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge. It then compares both outputs against that model at the next falling edge, once for every cycle. A configuration reload changes the outputs without a clock edge, so the bench checks them on the falling edge where the reload is released, before any strobe.

// File: rtl/jsf_pkg.sv
package jsf_pkg;

  // Strobes from the lock control to the instruction datapath
  typedef struct packed {
    logic loadCode;    // register the filtered shifted code
    logic loadIdcode;  // Test-Logic-Reset: force IDCODE
    logic setLock;     // external LOCK seen
    logic clrLock;     // external UNLOCK seen
  } jsfStrobe_t;

endpackage

// File: rtl/jsf_ctrl.sv
module jsf_ctrl #(
  parameter int          IR_W      = 10,
  parameter logic [IR_W-1:0] LOCK_OP   = 10'h1F0,
  parameter logic [IR_W-1:0] UNLOCK_OP = 10'h1F1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgSecureEn,
  input  logic                updateIr,
  input  logic                tlReset,
  input  logic [IR_W-1:0]     irCode,
  input  logic                fromExtPort,
  output jsf_pkg::jsfStrobe_t strobe,
  output logic                secureActive
);

  logic isLock;
  logic isUnlock;
  logic lockState;

  assign isLock   = (irCode == LOCK_OP);
  assign isUnlock = (irCode == UNLOCK_OP);

  always_comb begin
    strobe.loadIdcode = tlReset;
    strobe.loadCode   = updateIr && !tlReset;
    strobe.setLock    = strobe.loadCode && fromExtPort && isLock;
    strobe.clrLock    = strobe.loadCode && fromExtPort && isUnlock;
  end

  // Reload restores the configured value; Test-Logic-Reset does not touch it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lockState <= cfgSecureEn;
    else if (strobe.setLock) lockState <= 1'b1;
    else if (strobe.clrLock) lockState <= 1'b0;
  end

  assign secureActive = lockState;

endmodule

// File: rtl/jsf_datapath.sv
module jsf_datapath #(
  parameter int              IR_W      = 10,
  parameter logic [IR_W-1:0] BYPASS_OP = 10'h3FF,
  parameter logic [IR_W-1:0] SAMPLE_OP = 10'h005,
  parameter logic [IR_W-1:0] EXTEST_OP = 10'h00F,
  parameter logic [IR_W-1:0] IDCODE_OP = 10'h006,
  parameter logic [IR_W-1:0] LOCK_OP   = 10'h1F0,
  parameter logic [IR_W-1:0] UNLOCK_OP = 10'h1F1
) (
  input  logic                clk,
  input  logic                rstN,
  input  jsf_pkg::jsfStrobe_t strobe,
  input  logic                secureActive,
  input  logic [IR_W-1:0]     irCode,
  output logic [IR_W-1:0]     effInstr
);

  // Codes that pass while secure: mandatory set plus the two lock controls
  localparam int N_PASS = 6;
  localparam logic [IR_W-1:0] PASS_LIST [N_PASS] =
    '{BYPASS_OP, SAMPLE_OP, EXTEST_OP, IDCODE_OP, LOCK_OP, UNLOCK_OP};

  logic [N_PASS-1:0] hitVec;
  logic              onList;
  logic [IR_W-1:0]   passCode;
  logic [IR_W-1:0]   instrReg;

  for (genvar gi = 0; gi < N_PASS; gi++) begin : g_match
    assign hitVec[gi] = (irCode == PASS_LIST[gi]);
  end

  assign onList   = |hitVec;
  assign passCode = (!secureActive || onList) ? irCode : BYPASS_OP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  instrReg <= IDCODE_OP;
    else if (strobe.loadIdcode) instrReg <= IDCODE_OP;
    else if (strobe.loadCode)   instrReg <= passCode;
  end

  assign effInstr = instrReg;

endmodule

// File: rtl/jsf_sec_filter.sv
module jsf_sec_filter #(
  parameter int              IR_W      = 10,
  parameter logic [IR_W-1:0] BYPASS_OP = 10'h3FF,
  parameter logic [IR_W-1:0] SAMPLE_OP = 10'h005,
  parameter logic [IR_W-1:0] EXTEST_OP = 10'h00F,
  parameter logic [IR_W-1:0] IDCODE_OP = 10'h006,
  parameter logic [IR_W-1:0] LOCK_OP   = 10'h1F0,
  parameter logic [IR_W-1:0] UNLOCK_OP = 10'h1F1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgSecureEn,
  input  logic            updateIr,
  input  logic            tlReset,
  input  logic [IR_W-1:0] irCode,
  input  logic            fromExtPort,
  output logic [IR_W-1:0] effInstr,
  output logic            secureActive
);

  jsf_pkg::jsfStrobe_t strobe;

  jsf_ctrl #(
    .IR_W(IR_W), .LOCK_OP(LOCK_OP), .UNLOCK_OP(UNLOCK_OP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgSecureEn(cfgSecureEn),
    .updateIr(updateIr), .tlReset(tlReset), .irCode(irCode),
    .fromExtPort(fromExtPort), .strobe(strobe), .secureActive(secureActive)
  );

  jsf_datapath #(
    .IR_W(IR_W), .BYPASS_OP(BYPASS_OP), .SAMPLE_OP(SAMPLE_OP),
    .EXTEST_OP(EXTEST_OP), .IDCODE_OP(IDCODE_OP),
    .LOCK_OP(LOCK_OP), .UNLOCK_OP(UNLOCK_OP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .secureActive(secureActive),
    .irCode(irCode), .effInstr(effInstr)
  );

endmodule

// File: rtl/jsf_checker.sv
module jsf_checker #(
  parameter int              IR_W      = 10,
  parameter logic [IR_W-1:0] BYPASS_OP = 10'h3FF,
  parameter logic [IR_W-1:0] SAMPLE_OP = 10'h005,
  parameter logic [IR_W-1:0] EXTEST_OP = 10'h00F,
  parameter logic [IR_W-1:0] IDCODE_OP = 10'h006,
  parameter logic [IR_W-1:0] LOCK_OP   = 10'h1F0,
  parameter logic [IR_W-1:0] UNLOCK_OP = 10'h1F1
) (
  input logic            clk,
  input logic            rstN,
  input logic            updateIr,
  input logic            tlReset,
  input logic [IR_W-1:0] irCode,
  input logic            fromExtPort,
  input logic [IR_W-1:0] effInstr,
  input logic            secureActive
);

  logic upd;
  logic mandatory;
  logic lockCtl;

  assign upd       = updateIr && !tlReset;
  assign mandatory = (irCode == BYPASS_OP) || (irCode == SAMPLE_OP) ||
                     (irCode == EXTEST_OP) || (irCode == IDCODE_OP);
  assign lockCtl   = (irCode == LOCK_OP) || (irCode == UNLOCK_OP);

  AST_MANDATORY_PASS: assert property (@(posedge clk) disable iff (!rstN)
    upd && secureActive && mandatory |=> effInstr == $past(irCode)); // R2

  AST_BLOCKED_IS_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    upd && secureActive && !mandatory && !lockCtl |=> effInstr == BYPASS_OP); // R3

  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    upd && !secureActive |=> effInstr == $past(irCode)); // R4

  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    upd && fromExtPort && irCode == UNLOCK_OP |=> !secureActive); // R5

  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    upd && fromExtPort && irCode == LOCK_OP |=> secureActive); // R6

  AST_INTERNAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    updateIr && !fromExtPort |=> $stable(secureActive)); // R7

  AST_LOCKCTL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    upd && lockCtl |=> effInstr == $past(irCode)); // R8

  AST_TLR_IDCODE: assert property (@(posedge clk) disable iff (!rstN)
    tlReset |=> effInstr == IDCODE_OP && $stable(secureActive)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !updateIr && !tlReset |=> $stable(effInstr) && $stable(secureActive)); // R10

endmodule

bind jsf_sec_filter jsf_checker #(
  .IR_W(IR_W), .BYPASS_OP(BYPASS_OP), .SAMPLE_OP(SAMPLE_OP),
  .EXTEST_OP(EXTEST_OP), .IDCODE_OP(IDCODE_OP),
  .LOCK_OP(LOCK_OP), .UNLOCK_OP(UNLOCK_OP)
) u_jsf_checker (
  .clk(clk), .rstN(rstN), .updateIr(updateIr), .tlReset(tlReset),
  .irCode(irCode), .fromExtPort(fromExtPort),
  .effInstr(effInstr), .secureActive(secureActive)
);

// File: tb/test_jsf_sec_filter.sv
module test_jsf_sec_filter;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [9:0] C_BYPASS = 10'h3FF;
  localparam logic [9:0] C_SAMPLE = 10'h005;
  localparam logic [9:0] C_EXTEST = 10'h00F;
  localparam logic [9:0] C_IDCODE = 10'h006;
  localparam logic [9:0] C_LOCK   = 10'h1F0;
  localparam logic [9:0] C_UNLOCK = 10'h1F1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgSecureEn = 1'b1;
  logic       updateIr = 1'b0;
  logic       tlReset = 1'b0;
  logic [9:0] irCode = '0;
  logic       fromExtPort = 1'b1;
  logic [9:0] effInstr;
  logic       secureActive;

  int checks = 0;
  int failures = 0;
  bit mdlSecure;
  logic [9:0] mdlInstr;
  logic [9:0] passSet[$] = '{C_BYPASS, C_SAMPLE, C_EXTEST, C_IDCODE, C_LOCK, C_UNLOCK};

  always #2.5 clk = ~clk;

  jsf_sec_filter i_jsf_sec_filter (
    .clk(clk), .rstN(rstN), .cfgSecureEn(cfgSecureEn), .updateIr(updateIr),
    .tlReset(tlReset), .irCode(irCode), .fromExtPort(fromExtPort),
    .effInstr(effInstr), .secureActive(secureActive)
  );

  function automatic bit inPassSet(logic [9:0] c);
    foreach (passSet[k]) if (passSet[k] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (effInstr !== mdlInstr || secureActive !== mdlSecure) begin
      failures++;
      $display("FAIL %s: effInstr=%h secureActive=%b expected effInstr=%h secureActive=%b",
               tag, effInstr, secureActive, mdlInstr, mdlSecure);
    end
  endtask

  // One cycle: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic cyc(input bit up, input bit tlr, input bit ext,
                     input logic [9:0] code, input string tag);
    updateIr = up; tlReset = tlr; fromExtPort = ext; irCode = code;
    @(posedge clk);
    if (tlr) mdlInstr = C_IDCODE;
    else if (up) begin
      mdlInstr = (!mdlSecure || inPassSet(code)) ? code : C_BYPASS;
      if (ext && code == C_LOCK) mdlSecure = 1'b1;
      else if (ext && code == C_UNLOCK) mdlSecure = 1'b0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic reload(input bit cfg, input string tag);
    updateIr = 1'b0; tlReset = 1'b0;
    cfgSecureEn = cfg;
    rstN = 1'b0;
    @(negedge clk);
    mdlSecure = cfg; mdlInstr = C_IDCODE;
    compare(tag);
    rstN = 1'b1;
    compare(tag);
  endtask

  initial begin
    #1ms;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    reload(1'b1, "R1 reset secure");
    cfgSecureEn = 1'b0;
    cyc(0, 0, 1, 10'h2AA, "R10 cfg/irCode change idle");
    cyc(1, 0, 1, C_SAMPLE, "R2 SAMPLE passes locked");
    cyc(1, 0, 0, C_EXTEST, "R2 EXTEST passes locked");
    cyc(1, 0, 1, C_IDCODE, "R2 IDCODE passes locked");
    cyc(1, 0, 1, C_BYPASS, "R2 BYPASS passes locked");
    cyc(1, 0, 1, 10'h123, "R3 blocked code");
    cyc(1, 0, 0, 10'h000, "R3 blocked zero code");
    cyc(1, 0, 1, C_UNLOCK + 10'h1, "R3 near-unlock blocked");
    cyc(1, 0, 0, C_UNLOCK, "R7 internal UNLOCK ignored / R8 passed");
    cyc(0, 0, 1, C_UNLOCK, "R10 hold without strobe");
    cyc(1, 0, 1, C_LOCK, "R8 LOCK passed while locked");
    cyc(1, 0, 1, C_UNLOCK, "R5 external UNLOCK");
    cyc(1, 0, 1, 10'h123, "R4 open passes any");
    cyc(1, 0, 0, 10'h3C0, "R4 open passes internal");
    cyc(1, 0, 0, C_LOCK, "R7 internal LOCK ignored / R8 passed");
    cyc(1, 1, 1, C_LOCK, "R9 TLR wins over LOCK");
    cyc(1, 0, 1, C_LOCK, "R6 external LOCK");
    cyc(1, 0, 1, 10'h2AA, "R3 blocked after relock");
    cyc(0, 1, 1, 10'h2AA, "R9 TLR keeps secure");
    cyc(1, 0, 1, C_UNLOCK, "R5 unlock again");
    reload(1'b1, "R11 reload restores secure");
    reload(1'b0, "R11 reload with bit clear");
    cyc(1, 0, 1, 10'h155, "R4 open after reload");
    reload(1'b1, "R1 reset secure again");
    for (int i = 0; i < 400; i++) begin
      logic [9:0] code;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: code = C_LOCK;
        1: code = C_UNLOCK;
        2: code = C_SAMPLE;
        3: code = C_IDCODE;
        default: code = 10'($urandom);
      endcase
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 15) == 0,
          $urandom_range(0, 3) != 0, code, "R10 random mix R2 R3 R4 R5 R6 R7 R9");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule